// File: doc/BRIEF.md
# Periodic Tick Timer with APB Control

This peripheral sits on an APB3 bus and raises an interrupt once every X clock cycles while it is running. Software owns it through four word registers inside one 256-byte address window. Through these registers software can start and stop the count, clear the count, and change X while the timer runs. A flag records that at least one tick has happened since software last looked.

The interrupt output goes high for exactly one clock per expiry. This makes it safe to wire to a level-sensitive interrupt input: the line never stays asserted while software is in its handler. A small state machine with three states tracks whether the timer counts. TS_HALTED means the run bit is clear. TS_ZEROPER means the run bit is set but X is zero. TS_COUNTING means the run bit is set and X is nonzero. Its transitions are named start, stop, park (X written to zero while running) and unpark (X written nonzero while parked). Each transition is taken on the edge of the register write that causes it.

Top module: `tick_timer_apb`

## Requirements
- R1: Every APB transfer completes with zero wait states and no error. Registers are selected by paddr bits [7:2]: word 0 is control, word 1 is the period, word 2 is the count, word 3 is status. paddr bits [1:0] are ignored. Any other word reads as zero, and a write to it changes nothing.
- R2: Control bit 0 is the run bit and reads back. Control bit 1 is a restart strobe and always reads as 0. After reset the control, period, count and status registers all read 0 and the interrupt output is low.
- R3: With period P and run set, the first interrupt pulse appears P clocks after the edge of the write that set run from a count of 0. Later pulses follow every P clocks. Each pulse lasts one clock.
- R4: Writing 0 to the run bit freezes the count and stops all pulses. Setting run again resumes counting from the frozen value, so the next pulse comes P minus that value clocks after the write.
- R5: Writing 1 to control bit 1 clears the count to 0 on that edge and leaves the run bit and the period unchanged. If the restart lands on the edge where the count would wrap, no pulse is produced.
- R6: A period write takes effect for the compare after its own edge. If the count is then already at or above the new period minus one, the counter wraps and pulses on the very next edge. Otherwise it runs up to the new terminal value.
- R7: A period of 0 disables the timer. No pulses occur, the count holds, and the run bit keeps its value.
- R8: The count register at word 2 is read-only. A write to it leaves the count unchanged.
- R9: Status bit 0 is set on every edge that raises a pulse. A read of word 3 returns the value before clearing and then clears the bit. Reads of other words leave it alone.
- R10: When a pulse is raised on the same edge as a status read, the bit stays set. That read returns the old value and the next read returns 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and timer clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W (8) | Byte address inside the window |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, valid in the access phase |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Transfer error, always low |
| irq_o | output | 1 | One-clock interrupt pulse per expiry |

## Verification
Two events can fall on the same edge: the counter can wrap and set the status bit while a status read clears it. The restart strobe can also land on an edge where a wrap is due. The bench times a burst of back-to-back status reads against a four-cycle period so that one read's access edge coincides exactly with a wrap. It then judges both that read's returned value and the value of the following read. A restart is also issued on a wrap edge, and the scoreboard, which holds every expected pulse cycle, flags any pulse that fires there.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

    // word index of each register inside the window (paddr[7:2])
    localparam int IDX_CTRL   = 0;
    localparam int IDX_PERIOD = 1;
    localparam int IDX_COUNT  = 2;
    localparam int IDX_STATUS = 3;

    // control bit positions
    localparam int CTRL_RUN_BIT     = 0;
    localparam int CTRL_RESTART_BIT = 1;

    typedef enum logic [1:0] {
        TS_HALTED   = 2'd0,
        TS_ZEROPER  = 2'd1,
        TS_COUNTING = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/tick_timer_bus.sv
module tick_timer_bus
    import ptm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              run_i,
    input  logic [DATA_W-1:0] period_i,
    input  logic [DATA_W-1:0] count_i,
    input  logic              flag_i,
    output logic [DATA_W-1:0] prdata,
    output logic              ctrl_we,
    output logic              period_we,
    output logic              status_re
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             access;
    logic             unused_lsb;

    assign idx        = paddr[ADDR_W-1:2];
    assign unused_lsb = ^paddr[1:0];
    assign access     = psel & penable;

    assign ctrl_we   = access &  pwrite & (idx == IDX_W'(IDX_CTRL));
    assign period_we = access &  pwrite & (idx == IDX_W'(IDX_PERIOD));
    assign status_re = access & ~pwrite & (idx == IDX_W'(IDX_STATUS));

    always_comb begin
        prdata = '0;
        if (access && !pwrite) begin
            if (idx == IDX_W'(IDX_CTRL)) begin
                prdata[CTRL_RUN_BIT] = run_i;
            end else if (idx == IDX_W'(IDX_PERIOD)) begin
                prdata = period_i;
            end else if (idx == IDX_W'(IDX_COUNT)) begin
                prdata = count_i;
            end else if (idx == IDX_W'(IDX_STATUS)) begin
                prdata[0] = flag_i;
            end
        end
    end
endmodule

// File: rtl/tick_timer_flag.sv
module tick_timer_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // a tick on the same edge as a clearing read keeps the flag set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/tick_timer_engine.sv
module tick_timer_engine
    import ptm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             run_bit,
    input  logic             restart_bit,
    input  logic             period_we,
    input  logic [CNT_W-1:0] period_wdata,
    output tmr_state_e       state_o,
    output logic             run_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] count_o,
    output logic             restart_o,
    output logic             wrap_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] period_q, period_nx;
    logic [CNT_W-1:0] count_q, count_d;
    logic             run_now, run_nx;
    logic             restart, terminal, wrap;
    logic             irq_q;

    assign run_now   = (state_q != TS_HALTED);
    assign run_nx    = ctrl_we ? run_bit : run_now;
    assign period_nx = period_we ? period_wdata : period_q;
    assign restart   = ctrl_we & restart_bit;

    // next-state logic: start, stop, park, unpark
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_HALTED: begin
                if (run_nx) begin
                    state_d = (period_nx == '0) ? TS_ZEROPER : TS_COUNTING;
                end
            end
            TS_ZEROPER: begin
                if (!run_nx) begin
                    state_d = TS_HALTED;
                end else if (period_nx != '0) begin
                    state_d = TS_COUNTING;
                end
            end
            TS_COUNTING: begin
                if (!run_nx) begin
                    state_d = TS_HALTED;
                end else if (period_nx == '0) begin
                    state_d = TS_ZEROPER;
                end
            end
            default: state_d = TS_HALTED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TS_HALTED;
        end else begin
            state_q <= state_d;
        end
    end

    // period register: the compare sees a new value after its write edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
        end else begin
            period_q <= period_nx;
        end
    end

    assign terminal = (state_q == TS_COUNTING) && (count_q >= period_q - ONE);
    assign wrap     = terminal && !restart;

    always_comb begin
        count_d = count_q;
        if (restart) begin
            count_d = '0;
        end else if (state_q == TS_COUNTING) begin
            count_d = terminal ? '0 : count_q + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    // output register: one-clock pulse per wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= wrap;
        end
    end

    assign state_o   = state_q;
    assign run_o     = run_now;
    assign period_o  = period_q;
    assign count_o   = count_q;
    assign restart_o = restart;
    assign wrap_o    = wrap;
    assign irq_o     = irq_q;
endmodule

// File: rtl/tick_timer_apb.sv
module tick_timer_apb
    import ptm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq_o
);
    localparam int CNT_W = DATA_W;

    logic             ctrl_we, period_we, status_re;
    logic             run_w, flag_w, restart_w, wrap_w;
    logic [CNT_W-1:0] period_w, count_w;
    tmr_state_e       state_w;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    tick_timer_bus #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .run_i     (run_w),
        .period_i  (period_w),
        .count_i   (count_w),
        .flag_i    (flag_w),
        .prdata    (prdata),
        .ctrl_we   (ctrl_we),
        .period_we (period_we),
        .status_re (status_re)
    );

    tick_timer_engine #(
        .CNT_W (CNT_W)
    ) u_engine (
        .clk          (pclk),
        .rst_n        (presetn),
        .ctrl_we      (ctrl_we),
        .run_bit      (pwdata[CTRL_RUN_BIT]),
        .restart_bit  (pwdata[CTRL_RESTART_BIT]),
        .period_we    (period_we),
        .period_wdata (pwdata),
        .state_o      (state_w),
        .run_o        (run_w),
        .period_o     (period_w),
        .count_o      (count_w),
        .restart_o    (restart_w),
        .wrap_o       (wrap_w),
        .irq_o        (irq_o)
    );

    tick_timer_flag u_flag (
        .clk    (pclk),
        .rst_n  (presetn),
        .set_i  (wrap_w),
        .clr_i  (status_re),
        .flag_o (flag_w)
    );
endmodule

// File: rtl/tick_timer_apb_chk.sv
module tick_timer_apb_chk
    import ptm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             flag,
    input logic             restart,
    input tmr_state_e       state,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] period
);
    // R3: a pulse always leaves the counter at zero
    a_r3_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count == '0));

    // R3: pulse lasts one clock whenever the period exceeds one
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && period > CNT_W'(1)) |=> !irq);

    // R4: outside counting the count only moves through a restart
    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TS_COUNTING && !restart) |=> $stable(count));

    // R4: no pulse unless the timer was counting
    a_r4_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TS_COUNTING) |=> !irq);

    // R5: restart clears the count and suppresses the pulse
    a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0 && !irq));

    // R6: a count beyond the period wraps on the next edge
    a_r6_wrap_now: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_COUNTING && period != '0 && count >= period && !restart)
        |=> (count == '0 && irq));

    // R7: zero period produces no pulse
    a_r7_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0) |=> !irq);

    // R9 / R10: the flag is set whenever a pulse is out
    a_r10_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
endmodule

bind tick_timer_apb tick_timer_apb_chk #(.CNT_W(DATA_W)) u_chk (
    .clk     (pclk),
    .rst_n   (presetn),
    .irq     (irq_o),
    .flag    (flag_w),
    .restart (restart_w),
    .state   (state_w),
    .count   (count_w),
    .period  (period_w)
);

// File: tb/tick_timer_apb_test.sv
module tick_timer_apb_test;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam logic [7:0] A_CTRL = 8'h00, A_PER = 8'h04, A_CNT = 8'h08, A_STAT = 8'h0C;

    typedef struct {
        int    cyc;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [DATA_W-1:0] pwdata = '0;
    logic [DATA_W-1:0] prdata;
    logic              pready, pslverr, irq;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    tick_timer_apb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq_o(irq)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic push_exp(input int c, input string tag);
        exp_t e;
        e.cyc = c;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: every pulse must match the next expected cycle
    always @(negedge clk) begin
        if (rst_n && irq) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected pulse: actual cycle %0d expected none", cyc);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.cyc != cyc) begin
                    n_bad++;
                    $display("FAIL %s pulse: actual cycle %0d expected %0d", e.tag, cyc, e.cyc);
                end
            end
        end
    end

    task automatic drained(input string tag);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL %s missing pulse: actual none expected cycle %0d", tag, exp_q[0].cyc);
            exp_q.delete();
        end
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(posedge clk); @(negedge clk);
        penable = 1'b1;
        #1;
        n_chk++;
        if (pready !== 1'b1 || pslverr !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 handshake: actual %b%b expected 10", pready, pslverr);
        end
        @(posedge clk); @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(posedge clk); @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        @(posedge clk); @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic read_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        bus_read(a, v);
        check_eq(tag, v, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int w, s, w2, r, r2, c, d, z, q;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check_eq("R2 irq at reset", {31'b0, irq}, 32'd0);
        read_check(A_CTRL, 0, "R2 ctrl reset");
        read_check(A_PER,  0, "R2 period reset");
        read_check(A_CNT,  0, "R2 count reset");
        read_check(A_STAT, 0, "R2 status reset");

        // R1 decode, alignment, unmapped words
        bus_write(A_PER, 32'd7);
        read_check(8'h07, 32'd7, "R1 low address bits ignored");
        bus_write(8'h10, 32'hDEAD);
        read_check(8'h10, 32'd0, "R1 unmapped read");
        read_check(A_PER, 32'd7, "R1 unmapped write ignored");

        // R3 periodic pulses, then R4 stop
        w = cyc + 4;
        wait_until(w - 2);
        push_exp(w + 7, "R3"); push_exp(w + 14, "R3"); push_exp(w + 21, "R3");
        bus_write(A_CTRL, 32'd1);
        s = w + 24;
        wait_until(s - 2);
        bus_write(A_CTRL, 32'd0);
        wait_until(s + 30);
        drained("R3");
        read_check(A_CNT, 32'd3, "R4 count frozen");
        read_check(A_CTRL, 32'd0, "R4 run cleared");

        // R9 clear on read
        read_check(A_STAT, 32'd1, "R9 flag set");
        read_check(A_STAT, 32'd0, "R9 flag cleared by read");

        // R8 count is read-only
        bus_write(A_CNT, 32'h55);
        read_check(A_CNT, 32'd3, "R8 count write ignored");

        // R4 resume from held count
        w2 = cyc + 4;
        wait_until(w2 - 2);
        push_exp(w2 + 4, "R4"); push_exp(w2 + 11, "R4"); push_exp(w2 + 18, "R4");
        bus_write(A_CTRL, 32'd1);

        // R5 restart mid-period
        r = w2 + 20;
        wait_until(r - 2);
        push_exp(r + 7, "R5"); push_exp(r + 14, "R5");
        bus_write(A_CTRL, 32'd3);
        // R5 restart on a wrap edge: no pulse at r2
        r2 = r + 21;
        wait_until(r2 - 2);
        push_exp(r2 + 7, "R5");
        bus_write(A_CTRL, 32'd3);
        read_check(A_CTRL, 32'd1, "R5 run kept, restart reads 0");
        read_check(A_PER, 32'd7, "R5 period kept");

        // R6 shrink below current count: wraps on next edge
        c = r2 + 12;
        wait_until(c - 2);
        push_exp(c + 1, "R6"); push_exp(c + 4, "R6"); push_exp(c + 7, "R6"); push_exp(c + 10, "R6");
        bus_write(A_PER, 32'd3);
        // R6 grow: runs to new terminal value
        d = c + 11;
        wait_until(d - 2);
        push_exp(d + 5, "R6"); push_exp(d + 11, "R6");
        bus_write(A_PER, 32'd6);

        // R7 zero period
        z = d + 13;
        wait_until(z - 2);
        bus_write(A_PER, 32'd0);
        wait_until(z + 40);
        drained("R6");
        read_check(A_CNT, 32'd2, "R7 count held");
        read_check(A_CTRL, 32'd1, "R7 run kept");

        // R10 flag set and read clear on the same edge
        q = cyc + 4;
        wait_until(q - 2);
        push_exp(q + 2, "R10"); push_exp(q + 6, "R10"); push_exp(q + 10, "R10"); push_exp(q + 14, "R10");
        bus_write(A_PER, 32'd4);
        wait_until(q + 2);
        read_check(A_STAT, 32'd1, "R9 flag after pulse");
        wait_until(q + 6);
        read_check(A_STAT, 32'd1, "R10 read before collision");
        read_check(A_STAT, 32'd0, "R10 read on wrap edge returns old");
        read_check(A_STAT, 32'd1, "R10 set wins over clear");
        wait_until(q + 14);
        bus_write(A_CTRL, 32'd0);
        wait_until(q + 30);
        drained("R10");
        read_check(A_CNT, 32'd2, "R4 count frozen after stop");

        finish_run();
    end
endmodule